// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host port and an external asynchronous static RAM of 128K words by 16 bits. The RAM has one strobe for each byte lane. The host presents one request at a time: a read/write flag, a 17-bit word address, 16-bit write data and a 2-bit lane mask. The controller sequences active-low chip select, output enable, write enable and the two lane enables, and drives a tri-stated data bus. A read returns its data with a one-clock done pulse. A write reports completion with the same pulse.

Every phase is a whole number of system clocks. Each length is computed when the block is elaborated, by rounding a nanosecond limit of the memory up to clock periods. A grade parameter picks between the faster and the slower set of memory limits. The write pulse covers several limits at once: the minimum pulse width, the bus-release window of the memory followed by the data setup time, and the write cycle less one hold clock. The controller drives the data bus only inside a window that begins after the release wait and ends one clock after write enable rises.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, ready is 1, done is 0, and chip select, output enable, write enable and both lane enables are all high (inactive).
- R2: A request is taken only on a clock where both req_valid and ready are 1. From that clock, ready stays 0 until the done pulse has ended. Done is high for exactly one clock. Requests presented while ready is 0 have no effect on the memory.
- R3: A read holds chip select and output enable low and write enable high for RD_CLK clocks, where RD_CLK is 6 with the fast grade at a 10 ns clock. The address stays constant while chip select is low.
- R4: Read data is sampled on the last clock of the read phase. Done follows on the next clock, so done appears RD_CLK+1 clocks after acceptance. Lanes whose mask bit is 0 return zero. rdata keeps its value until the next read is sampled.
- R5: A write holds write enable low for WP_CLK clocks, where WP_CLK is 5 with the fast grade at 10 ns. Output enable stays high for the whole write. Chip select is low for WP_CLK+1 clocks, and done appears WP_CLK+2 clocks after acceptance. Only the lanes whose mask bit is 1 change in memory.
- R6: The controller starts driving the data bus no earlier than 20 ns after write enable falls. It keeps the data unchanged until one clock after write enable rises. It never drives the bus while output enable is low.
- R7: Write enable is low for at least 40 ns, and the write data is stable for at least 25 ns before write enable rises (fast grade).
- R8: A request with mask 00 raises done one clock after acceptance. It asserts no memory strobe and leaves the memory contents unchanged.
- R9: Each phase length is the nanosecond limit divided by the clock period and rounded up, with a minimum of one clock. With the slow grade at 10 ns, a read holds chip select low for 7 clocks and a write holds write enable low for 6 clocks.
- R10: mem_ub_n is low exactly when chip select is low and mask bit 1 is set. mem_lb_n is low exactly when chip select is low and mask bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while ready is 1 |
| req_write | input | 1 | 1 selects a write, 0 a read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 1 selects the upper byte, bit 0 the lower byte |
| ready | output | 1 | Controller is idle and can accept a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Data from the last read, with unselected lanes set to zero |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable (bits 15..8), active low |
| mem_lb_n | output | 1 | Lower lane enable (bits 7..0), active low |
| mem_dq | inout | 16 | Tri-stated memory data bus |

## Verification
A phase counter that stops at the wrong value shows up on the port pins within the same access. The low time of chip select, write enable or output enable comes out a clock too short or too long, and done arrives early or late. A lane register that is stuck or stale shows as a wrong lane enable on the very first access. The memory model in the bench rejects a write enable that rises too soon after the data starts to be driven, or data driven inside the release window. Either error is reported at the rising edge of write enable of the faulty write. A bad capture point shows as the model's placeholder word in rdata at the done pulse. A stray acceptance while busy shows up later, as a changed word when that address is read back.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_WPULSE = 3'd2,
    PH_WHOLD  = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  // active-high internal view of the memory strobes
  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
    logic drive;
  } strobe_t;

  localparam int unsigned BUS_RELEASE_NS = 20;

  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned rd_cycle_ns(input bit slow);
    return slow ? 70 : 55;
  endfunction

  function automatic int unsigned oe_access_ns(input bit slow);
    return slow ? 35 : 25;
  endfunction

  function automatic int unsigned we_pulse_ns(input bit slow);
    return slow ? 50 : 40;
  endfunction

  function automatic int unsigned wr_setup_ns(input bit slow);
    return slow ? 30 : 25;
  endfunction

  function automatic int unsigned wr_cycle_ns(input bit slow);
    return slow ? 70 : 55;
  endfunction

  function automatic int unsigned read_clocks(input bit slow, input int unsigned clk_ns);
    return max_u(ns_to_clk(rd_cycle_ns(slow), clk_ns), ns_to_clk(oe_access_ns(slow), clk_ns));
  endfunction

  function automatic int unsigned turn_clocks(input int unsigned clk_ns);
    return ns_to_clk(BUS_RELEASE_NS, clk_ns);
  endfunction

  function automatic int unsigned setup_clocks(input bit slow, input int unsigned clk_ns);
    return ns_to_clk(wr_setup_ns(slow), clk_ns);
  endfunction

  // write enable low time: pulse width, release wait plus setup, cycle minus the hold clock
  function automatic int unsigned pulse_clocks(input bit slow, input int unsigned clk_ns);
    int unsigned wc;
    wc = ns_to_clk(wr_cycle_ns(slow), clk_ns);
    wc = (wc > 1) ? wc - 1 : 1;
    return max_u(max_u(ns_to_clk(we_pulse_ns(slow), clk_ns),
                       turn_clocks(clk_ns) + setup_clocks(slow, clk_ns)), wc);
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned RD_CLK   = 6,
  parameter int unsigned WP_CLK   = 5,
  parameter int unsigned TURN_CLK = 2,
  parameter int unsigned CNT_W    = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    mask_zero,
  output logic    accept,
  output logic    ready,
  output logic    done,
  output logic    capture,
  output strobe_t nxt
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CLK - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CLK - 1);
  localparam logic [CNT_W-1:0] TURN_AT = CNT_W'(TURN_CLK);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          cnt_d  = '0;
          if (mask_zero)      phase_d = PH_DONE;
          else if (req_write) phase_d = PH_WPULSE;
          else                phase_d = PH_READ;
        end
      end
      PH_READ: begin
        if (cnt_q == RD_LAST) begin
          capture = 1'b1;
          phase_d = PH_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WPULSE: begin
        if (cnt_q == WP_LAST) begin
          phase_d = PH_WHOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WHOLD: phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  // strobes for the coming clock, registered at the pins
  always_comb begin
    nxt.sel   = (phase_d == PH_READ) || (phase_d == PH_WPULSE) || (phase_d == PH_WHOLD);
    nxt.rd    = (phase_d == PH_READ);
    nxt.wr    = (phase_d == PH_WPULSE);
    nxt.drive = ((phase_d == PH_WPULSE) && (cnt_d >= TURN_AT)) || (phase_d == PH_WHOLD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready = (phase_q == PH_IDLE);
  assign done  = (phase_q == PH_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready); // R2
  AST_CAPTURE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> done); // R4

endmodule

// File: rtl/sram_lane_pins.sv
`timescale 1ns/1ps
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LANES    = 2,
  parameter int unsigned WP_CLK   = 5,
  parameter int unsigned TURN_CLK = 2,
  parameter int unsigned DS_CLK   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  strobe_t           nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int unsigned MW = $clog2(WP_CLK + 2) + 1;

  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic              drv_q;
  logic [LANES-1:0]  lane_sel;
  logic [DATA_W-1:0] lane_bits;

  assign lane_sel = accept ? req_mask : be_q;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_bits[l*8 +: 8] = {8{be_q[l]}};
      assign mem_dq[l*8 +: 8]    = (drv_q && be_q[l]) ? wdata_q[l*8 +: 8] : 8'hzz;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      mem_cs_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_be_n <= '1;
      drv_q    <= 1'b0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        wdata_q  <= req_wdata;
        be_q     <= req_mask;
      end
      mem_cs_n <= ~nxt.sel;
      mem_oe_n <= ~nxt.rd;
      mem_we_n <= ~nxt.wr;
      mem_be_n <= ~(lane_sel & {LANES{nxt.sel}});
      drv_q    <= nxt.drive;
      if (capture) rdata <= mem_dq & lane_bits;
    end
  end

  // verification counters: write-enable low time and driven time inside it
  logic [MW-1:0] we_low_cnt;
  logic [MW-1:0] setup_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      setup_cnt  <= '0;
    end else begin
      we_low_cnt <= mem_we_n ? '0 : we_low_cnt + 1'b1;
      setup_cnt  <= mem_we_n ? '0 : (drv_q ? setup_cnt + 1'b1 : setup_cnt);
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R5
  AST_DRIVE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> mem_oe_n); // R6
  AST_TURN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q && !mem_we_n) |-> (we_low_cnt >= MW'(TURN_CLK))); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && !drv_q && (&mem_be_n))); // R10
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= MW'(WP_CLK))); // R7
  AST_SETUP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (setup_cnt >= MW'(DS_CLK))); // R7
  AST_CAPTURE_READING: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !mem_oe_n); // R4

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned CLK_NS     = 10,
  parameter bit          SLOW_GRADE = 1'b0,
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned RD_CLK   = read_clocks(SLOW_GRADE, CLK_NS);
  localparam int unsigned WP_CLK   = pulse_clocks(SLOW_GRADE, CLK_NS);
  localparam int unsigned TURN_CLK = turn_clocks(CLK_NS);
  localparam int unsigned DS_CLK   = setup_clocks(SLOW_GRADE, CLK_NS);
  localparam int unsigned CNT_W    = $clog2(max_u(RD_CLK, WP_CLK) + 1);

  logic         accept;
  logic         capture;
  strobe_t      nxt;
  logic [LANES-1:0] be_n;

  sram_lane_seq #(
    .RD_CLK  (RD_CLK),
    .WP_CLK  (WP_CLK),
    .TURN_CLK(TURN_CLK),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .mask_zero(~|req_mask),
    .accept   (accept),
    .ready    (ready),
    .done     (done),
    .capture  (capture),
    .nxt      (nxt)
  );

  sram_lane_pins #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LANES   (LANES),
    .WP_CLK  (WP_CLK),
    .TURN_CLK(TURN_CLK),
    .DS_CLK  (DS_CLK)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .capture  (capture),
    .nxt      (nxt),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_mask (req_mask[LANES-1:0]),
    .rdata    (rdata),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .mem_be_n (be_n),
    .mem_dq   (mem_dq)
  );

  assign mem_ub_n = be_n[LANES-1];
  assign mem_lb_n = be_n[0];

  AST_LANE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(accept)) |-> ((mem_ub_n == !$past(req_mask[1])) && (mem_lb_n == !$past(req_mask[0])))); // R10

endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cdiv(input int a, input int b);
    int c;
    c = (a + b - 1) / b;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bench's own view of the phase lengths at 10 ns
  localparam int T_NS = 10;
  int E_RD, E_WP, E_RD_S, E_WP_S;
  initial begin
    E_RD   = imax(cdiv(55, T_NS), cdiv(25, T_NS));
    E_WP   = imax(imax(cdiv(40, T_NS), cdiv(20, T_NS) + cdiv(25, T_NS)), cdiv(55, T_NS) - 1);
    E_RD_S = imax(cdiv(70, T_NS), cdiv(35, T_NS));
    E_WP_S = imax(imax(cdiv(50, T_NS), cdiv(20, T_NS) + cdiv(30, T_NS)), cdiv(70, T_NS) - 1);
  end

  // fast-grade instance
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        ready, done;
  logic [15:0] rdata;
  logic [16:0] mem_addr;
  logic        cs_n, oe_n, we_n, ub_n, lb_n;
  wire  [15:0] dq;

  sram_lane_ctrl #(.CLK_NS(10), .SLOW_GRADE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .ready(ready), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(cs_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
    .mem_ub_n(ub_n), .mem_lb_n(lb_n), .mem_dq(dq)
  );

  // slow-grade instance, strobes only
  logic        s_req_valid = 1'b0, s_req_write = 1'b0;
  logic        s_ready, s_done;
  logic [15:0] s_rdata;
  logic [16:0] s_mem_addr;
  logic        s_cs_n, s_oe_n, s_we_n, s_ub_n, s_lb_n;
  wire  [15:0] s_dq;

  sram_lane_ctrl #(.CLK_NS(10), .SLOW_GRADE(1'b1)) dut_slow_i (
    .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_write(s_req_write),
    .req_addr(17'h00011), .req_wdata(16'h7E81), .req_mask(2'b11),
    .ready(s_ready), .done(s_done), .rdata(s_rdata), .mem_addr(s_mem_addr),
    .mem_cs_n(s_cs_n), .mem_oe_n(s_oe_n), .mem_we_n(s_we_n),
    .mem_ub_n(s_ub_n), .mem_lb_n(s_lb_n), .mem_dq(s_dq)
  );

  // ---------------- behavioural memory model ----------------
  logic [15:0] mdl_mem [0:255];
  function automatic logic [15:0] init_word(input int i);
    return 16'((i * 257) ^ 16'h0F0F);
  endfunction
  initial for (int i = 0; i < 256; i++) mdl_mem[i] = init_word(i);

  logic       rd_act;
  logic [1:0] lane_rd;
  logic [1:0] lane_hold = 2'b00;
  logic [1:0] lane_last = 2'b00;
  logic       mdl_valid = 1'b0;
  logic [15:0] mdl_out;

  assign rd_act  = !cs_n && !oe_n && we_n;
  assign lane_rd = rd_act ? {!ub_n, !lb_n} : 2'b00;
  assign mdl_out = mdl_valid ? mdl_mem[mem_addr[7:0]] : 16'h5A5A;
  assign dq[7:0]  = (lane_rd[0] || lane_hold[0]) ? mdl_out[7:0]  : 8'hzz;
  assign dq[15:8] = (lane_rd[1] || lane_hold[1]) ? mdl_out[15:8] : 8'hzz;

  always @(posedge rd_act) begin
    mdl_valid = 1'b0;
    #55;
    if (rd_act) mdl_valid = 1'b1;
  end

  always @(lane_rd) begin
    if (lane_rd == 2'b00 && lane_last != 2'b00) begin
      lane_hold = lane_last;
      lane_last = 2'b00;
      #20;
      lane_hold = 2'b00;
    end else begin
      lane_last = lane_rd;
    end
  end

  longint t_wf = 0, t_dq = 0;
  bit          wr_seen = 1'b0;
  logic [15:0] wr_last = '0;
  logic [1:0]  wr_lanes = '0;

  always @(negedge we_n) t_wf = $time;
  always @(dq) if (!we_n) t_dq = $time;

  always @(posedge we_n) begin
    if (!cs_n) begin
      chk(($time - t_wf) >= 40, "R7 write pulse ns", int'($time - t_wf), 40);
      chk(($time - t_dq) >= 25, "R7 data setup ns", int'($time - t_dq), 25);
      chk((t_dq - t_wf) >= 20, "R6 turnaround ns", int'(t_dq - t_wf), 20);
      wr_lanes = {!ub_n, !lb_n};
      wr_last  = dq;
      if (!lb_n) mdl_mem[mem_addr[7:0]][7:0]  = dq[7:0];
      if (!ub_n) mdl_mem[mem_addr[7:0]][15:8] = dq[15:8];
      wr_seen = 1'b1;
    end
  end
  always @(posedge cs_n) wr_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 2; l++) begin
        if (lane_rd[l] || lane_hold[l])
          chk(dq[l*8 +: 8] == mdl_out[l*8 +: 8], "R6 no contention", int'(dq[l*8 +: 8]), int'(mdl_out[l*8 +: 8]));
      end
      if (wr_seen && !cs_n && we_n && oe_n) begin
        for (int l = 0; l < 2; l++)
          if (wr_lanes[l])
            chk(dq[l*8 +: 8] == wr_last[l*8 +: 8], "R6 data hold", int'(dq[l*8 +: 8]), int'(wr_last[l*8 +: 8]));
      end
    end
  end

  // ---------------- request driver ----------------
  int          r_lat, r_cs, r_we, r_oe, r_bad;
  logic [15:0] r_data;

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] m, input int stray);
    @(negedge clk);
    chk(ready == 1'b1, "R2 ready before request", int'(ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    r_lat = 1; r_cs = 0; r_we = 0; r_oe = 0; r_bad = 0;
    while (!done && r_lat < 100) begin
      if (r_lat <= stray) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00055; req_wdata = 16'hEEEE; req_mask = 2'b11;
      end else begin
        req_valid = 1'b0;
      end
      if (!cs_n) r_cs++;
      if (!we_n) r_we++;
      if (!oe_n) r_oe++;
      if (ready) r_bad++;
      if (!cs_n && (mem_addr != a || ub_n != !m[1] || lb_n != !m[0])) r_bad++;
      if (cs_n && (!ub_n || !lb_n)) r_bad++;
      @(negedge clk);
      r_lat++;
    end
    req_valid = 1'b0;
    r_data = rdata;
    chk(!ready, "R2 ready low during done", int'(ready), 0);
    @(negedge clk);
    chk(!done && ready, "R2 done single clock", int'({done, ready}), 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(ready && !done, "R1 ready/done after reset", int'({ready, done}), 2);
    chk({cs_n, oe_n, we_n, ub_n, lb_n} == 5'b11111, "R1 strobes idle", int'({cs_n, oe_n, we_n, ub_n, lb_n}), 31);
  endtask

  task automatic t_word_write_read();
    do_req(1'b1, 17'h00003, 16'hC3A7, 2'b11, 0);
    chk(r_lat == E_WP + 2, "R5 write latency", r_lat, E_WP + 2);
    chk(r_we == E_WP, "R5 we low clocks", r_we, E_WP);
    chk(r_cs == E_WP + 1, "R5 cs low clocks", r_cs, E_WP + 1);
    chk(r_oe == 0, "R5 oe stays high", r_oe, 0);
    chk(r_bad == 0, "R10 lanes/address/ready during write", r_bad, 0);
    do_req(1'b0, 17'h00003, 16'h0000, 2'b11, 0);
    chk(r_lat == E_RD + 1, "R4 read latency", r_lat, E_RD + 1);
    chk(r_cs == E_RD && r_oe == E_RD, "R3 read strobe clocks", r_cs, E_RD);
    chk(r_we == 0, "R3 we high in read", r_we, 0);
    chk(r_bad == 0, "R3 address and lanes stable", r_bad, 0);
    chk(r_data == 16'hC3A7, "R4 word read", int'(r_data), 16'hC3A7);
  endtask

  task automatic t_lanes();
    do_req(1'b1, 17'h00003, 16'h9E11, 2'b10, 0);
    chk(r_bad == 0, "R10 upper-only enables", r_bad, 0);
    do_req(1'b1, 17'h00003, 16'h44B6, 2'b01, 0);
    chk(r_bad == 0, "R10 lower-only enables", r_bad, 0);
    do_req(1'b0, 17'h00003, 16'h0000, 2'b11, 0);
    chk(r_data == 16'h9EB6, "R5 only masked lanes written", int'(r_data), 16'h9EB6);
    do_req(1'b0, 17'h00003, 16'h0000, 2'b01, 0);
    chk(r_data == 16'h00B6, "R4 lower lane read", int'(r_data), 16'h00B6);
    do_req(1'b0, 17'h00003, 16'h0000, 2'b10, 0);
    chk(r_data == 16'h9E00, "R4 upper lane read", int'(r_data), 16'h9E00);
  endtask

  task automatic t_zero_mask();
    do_req(1'b1, 17'h00003, 16'hFFFF, 2'b00, 0);
    chk(r_lat == 1, "R8 zero-mask latency", r_lat, 1);
    chk(r_cs == 0 && r_we == 0 && r_oe == 0, "R8 no strobes", r_cs + r_we + r_oe, 0);
    do_req(1'b0, 17'h00003, 16'h0000, 2'b11, 0);
    chk(r_data == 16'h9EB6, "R8 memory unchanged", int'(r_data), 16'h9EB6);
  endtask

  task automatic t_busy_ignore();
    do_req(1'b1, 17'h00009, 16'h1357, 2'b11, 3);
    chk(r_bad == 0, "R2 ready low while busy", r_bad, 0);
    do_req(1'b0, 17'h00055, 16'h0000, 2'b11, 0);
    chk(r_data == init_word(16'h55), "R2 busy request ignored", int'(r_data), int'(init_word(16'h55)));
    do_req(1'b0, 17'h00009, 16'h0000, 2'b11, 0);
    chk(r_data == 16'h1357, "R5 write under stray request", int'(r_data), 16'h1357);
  endtask

  task automatic t_rdata_hold();
    do_req(1'b1, 17'h00020, 16'h2468, 2'b11, 0);
    chk(rdata == 16'h1357, "R4 rdata held over write", int'(rdata), 16'h1357);
    do_req(1'b0, 17'h00021, 16'h0000, 2'b00, 0);
    chk(rdata == 16'h1357, "R4 rdata held over zero-mask read", int'(rdata), 16'h1357);
    do_req(1'b0, 17'h00040, 16'h0000, 2'b11, 0);
    chk(r_data == init_word(16'h40), "R4 untouched word", int'(r_data), int'(init_word(16'h40)));
  endtask

  task automatic t_slow_grade();
    int cs_lo, we_lo, n;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      s_req_valid = 1'b1; s_req_write = (k == 1);
      @(negedge clk);
      s_req_valid = 1'b0;
      cs_lo = 0; we_lo = 0; n = 0;
      while (!s_done && n < 100) begin
        if (!s_cs_n) cs_lo++;
        if (!s_we_n) we_lo++;
        @(negedge clk);
        n++;
      end
      if (k == 0) chk(cs_lo == E_RD_S, "R9 slow read cs clocks", cs_lo, E_RD_S);
      else        chk(we_lo == E_WP_S, "R9 slow we clocks", we_lo, E_WP_S);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word_write_read();
    t_lanes();
    t_zero_mask();
    t_busy_ignore();
    t_rdata_hold();
    t_slow_grade();
    repeat (4) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule